// File: doc/BRIEF.md
# Two-Buffer Receive Store with Data-Available Flag

This block sits between a USB packet engine and a CPU and holds received payloads in two 64-byte buffers. The engine claims a free buffer, streams payload bytes into it and ends the packet with either a commit, which records the byte count, or a discard, which hands the buffer straight back. Packets that failed their error or toggle checks are discarded by the engine and never reach the CPU.

The CPU sees one packet at a time, always the oldest committed one. A data-available flag tells it a packet is waiting. It reads the byte count from a count output and pulls the bytes one per access from a single data port, and each read advances an internal pointer. It then writes 1 to the flag. That write frees the buffer, and if the second buffer already holds a committed packet the flag comes back one cycle later. A status output tells the engine whether any buffer is free, so it can refuse a new packet when none is.

Top module: `rx_dbuf_fifo`

## Requirements
- R1: After reset the flag is 0, the count and data outputs are 0 and the free status is 1.
- R2: A commit pulse sampled at clock edge C raises the flag after edge C+1. The count output then shows the number of bytes written, and the data output shows those bytes in write order.
- R3: Each read pulse while the flag is 1 moves the read pointer by one byte. Once the pointer equals the byte count, the data output is 0 and further reads neither move the pointer nor change the output.
- R4: A flag write with data bit 1 while the flag is 1 clears the flag at the next edge and frees the buffer being read. A flag write with data bit 0 changes neither the flag, the count nor the data.
- R5: If the other buffer holds a committed packet when the flag is cleared, the flag is 0 for exactly one cycle and then rises again.
- R6: A discarded packet never raises the flag, and its buffer becomes free again.
- R7: The free status is 0 when neither buffer is free. A start request seen then is ignored, together with the writes and the commit that follow it.
- R8: A buffer holds at most 64 bytes. Writes beyond that are dropped and the committed count saturates at 64.
- R9: Packets reach the CPU in commit order, and each buffer keeps its own count. While the flag stays 1 the count output does not change.
- R10: A release and a commit in the same cycle both take effect. The newly committed packet is presented after the one-cycle gap of R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| eng_start_i | input | 1 | Engine claims a free buffer for a new packet |
| eng_wr_i | input | 1 | Engine writes one payload byte |
| eng_data_i | input | 8 | Payload byte |
| eng_commit_i | input | 1 | End of a good packet: commit buffer with count |
| eng_discard_i | input | 1 | End of a bad packet: drop buffer |
| eng_free_o | output | 1 | At least one buffer is free |
| cpu_rd_i | input | 1 | CPU read access to the data register |
| cpu_rdata_o | output | 8 | Byte at the read pointer, 0 past the count |
| cpu_count_o | output | 7 | Byte count of the buffer being read |
| cpu_flag_wr_i | input | 1 | CPU write to the data-available flag |
| cpu_flag_wdata_i | input | 1 | Write data; 1 clears the flag |
| davail_o | output | 1 | Data-available flag and interrupt |

## Verification
The engine can commit one buffer in the same cycle that the CPU releases the other. Both actions move the pointer to the buffer being read, and both change buffer ownership. The bench raises the commit pulse and the flag write on the same clock edge. It then expects the flag to be low for one cycle and to come back with the count and bytes of the new packet. It also checks that the engine can claim the buffer just released.

// File: rtl/rxb_pkg.sv
package rxb_pkg;
  localparam int NUM_BUF = 2;
  localparam int BUF_W   = 1;

  typedef enum logic [1:0] {
    BUF_FREE = 2'd0,
    BUF_FILL = 2'd1,
    BUF_FULL = 2'd2
  } buf_state_e;
endpackage

// File: rtl/rxb_store.sv
module rxb_store
  import rxb_pkg::*;
#(
  parameter int DW    = 8,
  parameter int DEPTH = 64,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             we_i,
  input  logic [BUF_W-1:0] wbuf_i,
  input  logic [AW-1:0]    waddr_i,
  input  logic [DW-1:0]    wdata_i,
  input  logic [BUF_W-1:0] rbuf_i,
  input  logic [AW-1:0]    raddr_i,
  output logic [DW-1:0]    rdata_o
);
  logic [DW-1:0] mem_q [NUM_BUF][DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[wbuf_i][waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[rbuf_i][raddr_i];
endmodule

// File: rtl/rxb_fill.sv
module rxb_fill
  import rxb_pkg::*;
#(
  parameter int DW    = 8,
  parameter int DEPTH = 64,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic               wr_i,
  input  logic [DW-1:0]      data_i,
  input  logic               commit_i,
  input  logic               discard_i,
  input  logic [NUM_BUF-1:0] free_vec_i,
  output logic               alloc_o,
  output logic               commit_o,
  output logic               discard_o,
  output logic [BUF_W-1:0]   idx_o,
  output logic [CW-1:0]      len_o,
  output logic               we_o,
  output logic [AW-1:0]      waddr_o,
  output logic [DW-1:0]      wdata_o
);
  logic             active_q;
  logic [BUF_W-1:0] idx_q, pick;
  logic [CW-1:0]    ptr_q;

  // lowest-index free buffer
  always_comb begin
    pick = '0;
    for (int b = NUM_BUF - 1; b >= 0; b--) begin
      if (free_vec_i[b]) pick = BUF_W'(b);
    end
  end

  assign alloc_o   = start_i && !active_q && |free_vec_i;
  assign commit_o  = active_q && commit_i;
  assign discard_o = active_q && discard_i && !commit_i;
  // the cycle that ends a packet carries no data
  assign we_o      = active_q && wr_i && !commit_i && !discard_i && (ptr_q < CW'(DEPTH));
  assign waddr_o   = ptr_q[AW-1:0];
  assign wdata_o   = data_i;
  assign idx_o     = alloc_o ? pick : idx_q;
  assign len_o     = ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      idx_q    <= '0;
      ptr_q    <= '0;
    end else if (alloc_o) begin
      active_q <= 1'b1;
      idx_q    <= pick;
      ptr_q    <= '0;
    end else if (commit_o || discard_o) begin
      active_q <= 1'b0;
    end else if (we_o) begin
      ptr_q <= ptr_q + 1'b1;
    end
  end
endmodule

// File: rtl/rxb_owner.sv
module rxb_owner
  import rxb_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               alloc_i,
  input  logic               commit_i,
  input  logic               discard_i,
  input  logic [BUF_W-1:0]   idx_i,
  input  logic [CW-1:0]      len_i,
  input  logic               rd_i,
  input  logic               flag_wr_i,
  input  logic               flag_wdata_i,
  output logic [NUM_BUF-1:0] free_vec_o,
  output logic               davail_o,
  output logic [BUF_W-1:0]   head_o,
  output logic [AW-1:0]      raddr_o,
  output logic               rvalid_o,
  output logic [CW-1:0]      count_o
);
  buf_state_e       state_q [NUM_BUF];
  logic [CW-1:0]    cnt_q   [NUM_BUF];
  logic [BUF_W-1:0] head_q;
  logic             davail_q;
  logic [CW-1:0]    rd_ptr_q;
  logic             release_w, rd_adv, head_full;

  for (genvar b = 0; b < NUM_BUF; b++) begin : g_free
    assign free_vec_o[b] = (state_q[b] == BUF_FREE);
  end

  assign head_full = (state_q[head_q] == BUF_FULL);
  assign release_w = flag_wr_i && flag_wdata_i && davail_q;
  assign rd_adv    = rd_i && davail_q && !release_w && (rd_ptr_q < cnt_q[head_q]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int b = 0; b < NUM_BUF; b++) begin
        state_q[b] <= BUF_FREE;
        cnt_q[b]   <= '0;
      end
    end else begin
      for (int b = 0; b < NUM_BUF; b++) begin
        if (alloc_i && idx_i == BUF_W'(b)) begin
          state_q[b] <= BUF_FILL;
        end else if (commit_i && idx_i == BUF_W'(b)) begin
          state_q[b] <= BUF_FULL;
          cnt_q[b]   <= len_i;
        end else if (discard_i && idx_i == BUF_W'(b)) begin
          state_q[b] <= BUF_FREE;
        end else if (release_w && head_q == BUF_W'(b)) begin
          state_q[b] <= BUF_FREE;
        end
      end
    end
  end

  // head tracks the oldest committed buffer
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      head_q   <= '0;
      davail_q <= 1'b0;
      rd_ptr_q <= '0;
    end else begin
      if (release_w)                  head_q <= head_q + 1'b1;
      else if (commit_i && !head_full) head_q <= idx_i;
      davail_q <= release_w ? 1'b0 : head_full;
      if (release_w)   rd_ptr_q <= '0;
      else if (rd_adv) rd_ptr_q <= rd_ptr_q + 1'b1;
    end
  end

  assign davail_o = davail_q;
  assign head_o   = head_q;
  assign raddr_o  = rd_ptr_q[AW-1:0];
  assign rvalid_o = davail_q && (rd_ptr_q < cnt_q[head_q]);
  assign count_o  = davail_q ? cnt_q[head_q] : '0;
endmodule

// File: rtl/rx_dbuf_fifo.sv
module rx_dbuf_fifo
  import rxb_pkg::*;
#(
  parameter int DW    = 8,
  parameter int DEPTH = 64,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          eng_start_i,
  input  logic          eng_wr_i,
  input  logic [DW-1:0] eng_data_i,
  input  logic          eng_commit_i,
  input  logic          eng_discard_i,
  output logic          eng_free_o,
  input  logic          cpu_rd_i,
  output logic [DW-1:0] cpu_rdata_o,
  output logic [CW-1:0] cpu_count_o,
  input  logic          cpu_flag_wr_i,
  input  logic          cpu_flag_wdata_i,
  output logic          davail_o
);
  logic               alloc, commit, discard, we, rvalid;
  logic [BUF_W-1:0]   idx, head;
  logic [CW-1:0]      len;
  logic [AW-1:0]      waddr, raddr;
  logic [DW-1:0]      wdata, mem_rdata;
  logic [NUM_BUF-1:0] free_vec;

  rxb_fill #(.DW(DW), .DEPTH(DEPTH)) u_fill (
    .clk_i, .rst_ni,
    .start_i(eng_start_i), .wr_i(eng_wr_i), .data_i(eng_data_i),
    .commit_i(eng_commit_i), .discard_i(eng_discard_i),
    .free_vec_i(free_vec),
    .alloc_o(alloc), .commit_o(commit), .discard_o(discard),
    .idx_o(idx), .len_o(len),
    .we_o(we), .waddr_o(waddr), .wdata_o(wdata)
  );

  rxb_owner #(.DEPTH(DEPTH)) u_owner (
    .clk_i, .rst_ni,
    .alloc_i(alloc), .commit_i(commit), .discard_i(discard),
    .idx_i(idx), .len_i(len),
    .rd_i(cpu_rd_i), .flag_wr_i(cpu_flag_wr_i), .flag_wdata_i(cpu_flag_wdata_i),
    .free_vec_o(free_vec), .davail_o(davail_o), .head_o(head),
    .raddr_o(raddr), .rvalid_o(rvalid), .count_o(cpu_count_o)
  );

  rxb_store #(.DW(DW), .DEPTH(DEPTH)) u_store (
    .clk_i,
    .we_i(we), .wbuf_i(idx), .waddr_i(waddr), .wdata_i(wdata),
    .rbuf_i(head), .raddr_i(raddr), .rdata_o(mem_rdata)
  );

  assign eng_free_o  = |free_vec;
  assign cpu_rdata_o = rvalid ? mem_rdata : '0;
endmodule

// File: rtl/rx_dbuf_fifo_chk.sv
module rx_dbuf_fifo_chk #(
  parameter int DW    = 8,
  parameter int DEPTH = 64,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          davail_o,
  input logic          cpu_flag_wr_i,
  input logic          cpu_flag_wdata_i,
  input logic [CW-1:0] cpu_count_o
);
  logic clr;
  assign clr = cpu_flag_wr_i && cpu_flag_wdata_i;

  assert_clear_drops_flag_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    davail_o && clr |=> !davail_o);

  assert_flag_holds_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    davail_o && !clr |=> davail_o);

  assert_count_stable_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    davail_o && !clr |=> $stable(cpu_count_o));

  assert_count_bound_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_count_o <= CW'(DEPTH));
endmodule

bind rx_dbuf_fifo rx_dbuf_fifo_chk #(.DW(DW), .DEPTH(DEPTH)) u_chk (
  .clk_i, .rst_ni, .davail_o, .cpu_flag_wr_i, .cpu_flag_wdata_i, .cpu_count_o
);

// File: tb/sim_rx_dbuf_fifo.sv
module sim_rx_dbuf_fifo;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0, wr = 1'b0, commit = 1'b0, discard = 1'b0;
  logic [7:0] data = '0;
  logic       free, rd = 1'b0, fwr = 1'b0, fdat = 1'b0, davail;
  logic [7:0] rdata;
  logic [6:0] count;
  int         checks = 0, errors = 0;
  bit         done = 1'b0;

  always #5 clk = ~clk;

  rx_dbuf_fifo u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .eng_start_i(start), .eng_wr_i(wr), .eng_data_i(data),
    .eng_commit_i(commit), .eng_discard_i(discard), .eng_free_o(free),
    .cpu_rd_i(rd), .cpu_rdata_o(rdata), .cpu_count_o(count),
    .cpu_flag_wr_i(fwr), .cpu_flag_wdata_i(fdat), .davail_o(davail)
  );

  // {len[6:0], seed[7:0], commit}
  localparam int NV = 6;
  localparam logic [15:0] VEC [NV] = '{
    {7'd1,  8'h11, 1'b1}, {7'd4,  8'hA0, 1'b1}, {7'd9,  8'h30, 1'b0},
    {7'd0,  8'h00, 1'b1}, {7'd17, 8'hF8, 1'b1}, {7'd5,  8'h55, 1'b0}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  // start, write len bytes seed+i, end with commit or discard; end pulse is left to caller when hold=1
  task automatic fill(input int len, input logic [7:0] seed, input bit good, input bit hold);
    start = 1'b1; cyc(); start = 1'b0;
    for (int i = 0; i < len; i++) begin
      wr = 1'b1; data = seed + 8'(i); cyc();
    end
    wr = 1'b0;
    if (!hold) begin
      if (good) commit = 1'b1; else discard = 1'b1;
      cyc();
      commit = 1'b0; discard = 1'b0;
    end
  endtask

  task automatic drain(input int len, input logic [7:0] seed, input string req);
    chk(davail == 1'b1, req, davail, 1);
    chk(count == 7'(len), req, count, len);
    for (int i = 0; i < len; i++) begin
      chk(rdata == seed + 8'(i), req, rdata, seed + 8'(i));
      rd = 1'b1; cyc(); rd = 1'b0;
    end
    for (int i = 0; i < 2; i++) begin
      chk(rdata == 8'h00, "R3", rdata, 0);
      rd = 1'b1; cyc(); rd = 1'b0;
    end
    chk(rdata == 8'h00 && count == 7'(len), "R3", rdata, 0);
  endtask

  task automatic release_flag();
    fwr = 1'b1; fdat = 1'b1; cyc(); fwr = 1'b0; fdat = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    cyc(); cyc();
    // R1 reset state
    chk(davail == 1'b0 && count == 0 && rdata == 0 && free == 1'b1, "R1", davail, 0);
    rst_n = 1'b1; cyc();
    chk(davail == 1'b0 && free == 1'b1, "R1", free, 1);

    for (int v = 0; v < NV; v++) begin
      int         len  = int'(VEC[v][15:9]);
      logic [7:0] seed = VEC[v][8:1];
      bit         good = VEC[v][0];
      fill(len, seed, good, 1'b0);
      chk(davail == 1'b0, good ? "R2" : "R6", davail, 0);
      cyc();
      if (good) begin
        drain(len, seed, "R2");
        release_flag();
        chk(davail == 1'b0, "R4", davail, 0);
        cyc();
        chk(davail == 1'b0 && free == 1'b1, "R4", davail, 0);
      end else begin
        cyc(); cyc();
        chk(davail == 1'b0 && count == 0, "R6", davail, 0);
        chk(free == 1'b1, "R6", free, 1);
      end
    end

    // R8 capacity
    fill(70, 8'h40, 1'b1, 1'b0); cyc();
    chk(count == 7'd64, "R8", count, 64);
    drain(64, 8'h40, "R8");
    release_flag(); cyc();

    // R9 order, R7 full status, R5 re-assert, R4 write of 0
    fill(3, 8'h10, 1'b1, 1'b0);
    fill(5, 8'h50, 1'b1, 1'b0);
    cyc();
    chk(free == 1'b0, "R7", free, 0);
    fill(2, 8'hEE, 1'b1, 1'b0);
    chk(free == 1'b0 && count == 7'd3, "R7", count, 3);
    fwr = 1'b1; fdat = 1'b0; cyc(); fwr = 1'b0; cyc();
    chk(davail == 1'b1 && count == 7'd3 && rdata == 8'h10, "R4", count, 3);
    drain(3, 8'h10, "R9");
    release_flag();
    chk(davail == 1'b0, "R5", davail, 0);
    chk(free == 1'b1, "R4", free, 1);
    cyc();
    chk(davail == 1'b1, "R5", davail, 1);
    drain(5, 8'h50, "R9");
    release_flag(); cyc(); cyc();
    chk(davail == 1'b0 && free == 1'b1, "R5", davail, 0);

    // R10 release and commit in the same cycle
    fill(2, 8'h70, 1'b1, 1'b0); cyc();
    chk(davail == 1'b1 && count == 7'd2, "R10", count, 2);
    fill(4, 8'h90, 1'b1, 1'b1);
    commit = 1'b1; fwr = 1'b1; fdat = 1'b1; cyc();
    commit = 1'b0; fwr = 1'b0; fdat = 1'b0;
    chk(davail == 1'b0, "R10", davail, 0);
    cyc();
    chk(davail == 1'b1, "R10", davail, 1);
    drain(4, 8'h90, "R10");
    fill(1, 8'h21, 1'b1, 1'b0);
    chk(free == 1'b0, "R10", free, 0);
    release_flag(); cyc();
    drain(1, 8'h21, "R10");
    release_flag(); cyc();
    chk(free == 1'b1 && davail == 1'b0, "R10", free, 1);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule